// File: doc/BRIEF.md
# Staggered-Slice Pipelined Integer ALU

This block is a 32-bit integer ALU built as eight 4-bit slices, each with its own registers. The slices are offset in time: slice k works on an operation exactly k cycles after slice 0 does. The operands enter in this staggered form and the results leave in the same form. An operation is issued by raising `issue_vld` with its opcode while lane 0 of both operands is presented. Lane k of the same operands must then appear on the operand buses k cycles later.

Every slice registers its part of the result, a carry toward the next slice, and the opcode with a valid bit. These registered values arrive at the next slice in step with that slice's delayed operand bits. Because of this, a result lane can be wired straight back into the same lane of the next operation. A chain of dependent operations then issues one per cycle, without waiting for the whole word. Signed overflow and the set-less-than bit depend on the top slice, so they leave together with the top lane.

Top module: `skew_alu`

## Requirements
- R1: While `rst_n` is low, and from the first cycle after it falls, `res_vld`, `ovf_flag` and `slt_bit` are all zero.
- R2: Take an operation whose lane 0 is presented in cycle t, with lane k of the operands presented in cycle t+k. Lane k of its result is on `res_sk[4k+3:4k]`, with `res_vld[k]` high, in cycle t+k+1. A new operation can be issued in every cycle.
- R3: Opcode 0 adds and opcode 1 subtracts (A plus inverted B plus one). The carry ripples from each slice to the next one cycle later, so the 32-bit result is exact modulo 2^32.
- R4: Opcodes 2, 3, 4 and 5 give bitwise AND, OR, XOR and NOR of the two operands in every lane.
- R5: `ovf_flag` is high in cycle t+8, the same cycle as `res_vld[7]`, exactly when an opcode 0 or 1 operation overflows as a signed 32-bit operation. It is low for every other opcode and in every other cycle.
- R6: Opcode 6 (signed set-less-than) drives all result lanes to zero. It reports signed A<B on `slt_bit` in cycle t+8, and the answer is correct even when A-B overflows. `slt_bit` is low at all other times.
- R7: Lane k of a result can be fed directly to lane k of operand A of the operation issued in the next cycle. Back-to-back dependent operations then give the same results as if they had been executed in sequence.
- R8: Opcode 7 gives a zero result with both flags low, and its lanes are still marked valid.
- R9: A cycle with `issue_vld` low produces no valid lane, whatever is on the operand lanes. The operations issued around it are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | Starts an operation whose lane 0 is on the operand buses this cycle |
| issue_op | input | 3 | Opcode issued with `issue_vld` |
| a_sk | input | 32 | Operand A; lane k belongs to the operation issued k cycles earlier |
| b_sk | input | 32 | Operand B, with the same lane staggering |
| res_sk | output | 32 | Result; lane k belongs to the operation issued k+1 cycles earlier |
| res_vld | output | 8 | Per-lane valid for `res_sk` |
| ovf_flag | output | 1 | Signed overflow of ADD/SUB, aligned with lane 7 |
| slt_bit | output | 1 | Set-less-than answer, aligned with lane 7 |

## Verification
The hardest case to reach is a run of back-to-back dependent operations. In such a run, every result lane has to be routed into the next operation's operand lane in the very cycle that lane appears. The bench keeps a per-lane history of issued operations. It drives each lane of operand A either from its own stored value or from the live `res_sk` lane, and it predicts the whole chain from its reference model. The chain includes carries that ripple through all eight slices and operand values with overflow, so a carry or opcode that is misaligned by one cycle corrupts a high lane.

// File: rtl/skew_alu_pkg.sv
package skew_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5,
        OP_SLT = 3'd6,
        OP_NOP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    vld;
        alu_op_e op;
    } lane_ctl_t;

    function automatic logic op_inverts_b(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT);
    endfunction
endpackage

// File: rtl/slice_core.sv
module slice_core
    import skew_alu_pkg::*;
#(
    parameter int SW = 4
) (
    input  alu_op_e        op,
    input  logic [SW-1:0]  a,
    input  logic [SW-1:0]  b,
    input  logic           cin,
    output logic [SW-1:0]  res,
    output logic           cout,
    output logic           ovf_raw,
    output logic           slt_raw
);
    logic [SW-1:0] b_eff;
    logic [SW:0]   sum;

    always_comb begin
        b_eff   = op_inverts_b(op) ? ~b : b;
        sum     = {1'b0, a} + {1'b0, b_eff} + {{SW{1'b0}}, cin};
        unique case (op)
            OP_ADD, OP_SUB: res = sum[SW-1:0];
            OP_AND:         res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_NOR:         res = ~(a | b);
            default:        res = '0;
        endcase
        cout    = op_is_arith(op) ? sum[SW] : 1'b0;
        ovf_raw = (a[SW-1] == b_eff[SW-1]) && (sum[SW-1] != a[SW-1]);
        slt_raw = sum[SW-1] ^ ovf_raw;
    end
endmodule

// File: rtl/skew_slice.sv
module skew_slice
    import skew_alu_pkg::*;
#(
    parameter int SW     = 4,
    parameter bit IS_MSB = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  lane_ctl_t      ctl_i,
    input  logic [SW-1:0]  a_i,
    input  logic [SW-1:0]  b_i,
    input  logic           cin_i,
    output lane_ctl_t      ctl_o,
    output logic [SW-1:0]  res_o,
    output logic           cout_o,
    output logic           ovf_o,
    output logic           slt_o
);
    typedef struct packed {
        lane_ctl_t     ctl;
        logic [SW-1:0] res;
        logic          cout;
        logic          ovf;
        logic          slt;
    } slice_st_t;

    slice_st_t     st_d, st_q;
    logic [SW-1:0] core_res;
    logic          core_cout, core_ovf, core_slt;

    slice_core #(.SW(SW)) u_core (
        .op      (ctl_i.op),
        .a       (a_i),
        .b       (b_i),
        .cin     (cin_i),
        .res     (core_res),
        .cout    (core_cout),
        .ovf_raw (core_ovf),
        .slt_raw (core_slt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ctl  = ctl_i;
        st_d.res  = core_res;
        st_d.cout = ctl_i.vld & core_cout;
        st_d.ovf  = IS_MSB && ctl_i.vld && core_ovf
                    && ((ctl_i.op == OP_ADD) || (ctl_i.op == OP_SUB));
        st_d.slt  = IS_MSB && ctl_i.vld && core_slt && (ctl_i.op == OP_SLT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o  = st_q.ctl;
    assign res_o  = st_q.res;
    assign cout_o = st_q.cout;
    assign ovf_o  = st_q.ovf;
    assign slt_o  = st_q.slt;
endmodule

// File: rtl/skew_alu.sv
module skew_alu
    import skew_alu_pkg::*;
#(
    parameter int SW     = 4,
    parameter int SLICES = 8,
    localparam int W     = SW * SLICES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [2:0]        issue_op,
    input  logic [W-1:0]      a_sk,
    input  logic [W-1:0]      b_sk,
    output logic [W-1:0]      res_sk,
    output logic [SLICES-1:0] res_vld,
    output logic              ovf_flag,
    output logic              slt_bit
);
    lane_ctl_t         ctl_src [SLICES];
    lane_ctl_t         ctl_w   [SLICES];
    logic              cin_src [SLICES];
    logic              carry_w [SLICES];
    logic [SLICES-1:0] ovf_w, slt_w;

    for (genvar k = 0; k < SLICES; k++) begin : g_lane
        if (k == 0) begin : g_head
            assign ctl_src[k] = '{vld: issue_vld, op: alu_op_e'(issue_op)};
            assign cin_src[k] = issue_vld & op_inverts_b(alu_op_e'(issue_op));
        end else begin : g_body
            assign ctl_src[k] = ctl_w[k-1];
            assign cin_src[k] = carry_w[k-1];

            // R2
            skew_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctl_w[k].vld == $past(ctl_w[k-1].vld));
        end

        skew_slice #(.SW(SW), .IS_MSB(k == SLICES - 1)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_i  (ctl_src[k]),
            .a_i    (a_sk[k*SW +: SW]),
            .b_i    (b_sk[k*SW +: SW]),
            .cin_i  (cin_src[k]),
            .ctl_o  (ctl_w[k]),
            .res_o  (res_sk[k*SW +: SW]),
            .cout_o (carry_w[k]),
            .ovf_o  (ovf_w[k]),
            .slt_o  (slt_w[k])
        );

        assign res_vld[k] = ctl_w[k].vld;

        // R3
        carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            carry_w[k] |-> (ctl_w[k].vld && op_is_arith(ctl_w[k].op)));
    end

    assign ovf_flag = |ovf_w;
    assign slt_bit  = |slt_w;

    // R5
    ovf_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (res_vld[SLICES-1] &&
                      ((ctl_w[SLICES-1].op == OP_ADD) || (ctl_w[SLICES-1].op == OP_SUB))));

    // R6
    slt_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slt_bit |-> (res_vld[SLICES-1] && (ctl_w[SLICES-1].op == OP_SLT)));

    // R6
    slt_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld[0] && (ctl_w[0].op == OP_SLT)) |-> (res_sk[SW-1:0] == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (res_vld == '0 && !ovf_flag && !slt_bit));
endmodule

// File: tb/tb_skew_alu.sv
module tb_skew_alu;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 4;
    localparam int SL  = 8;
    localparam int W   = SW * SL;
    localparam int MAXOPS = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_vld = 1'b0;
    logic [2:0]    issue_op = 3'd0;
    logic [W-1:0]  a_sk = '0, b_sk = '0;
    logic [W-1:0]  res_sk;
    logic [SL-1:0] res_vld;
    logic          ovf_flag, slt_bit;

    int checks = 0, failures = 0, nops = 0;
    bit done = 0;
    int hidx [SL];
    logic [2:0]  op_q   [MAXOPS];
    logic [31:0] a_q    [MAXOPS];
    logic [31:0] b_q    [MAXOPS];
    logic [31:0] exp_q  [MAXOPS];
    logic        eovf_q [MAXOPS];
    logic [31:0] got_q  [MAXOPS];
    bit          fwd_q  [MAXOPS];
    string       tag_q  [MAXOPS];

    skew_alu #(.SW(SW), .SLICES(SL)) dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_op(issue_op),
        .a_sk(a_sk), .b_sk(b_sk), .res_sk(res_sk), .res_vld(res_vld),
        .ovf_flag(ovf_flag), .slt_bit(slt_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [32:0] ref_calc(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [31:0] r;
        logic ov;
        ov = 1'b0;
        case (op)
            3'd0: begin r = a + b; ov = (a[31] == b[31]) && (r[31] != a[31]); end
            3'd1: begin r = a - b; ov = (a[31] != b[31]) && (r[31] != a[31]); end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = ~(a | b);
            3'd6: r = {31'd0, ($signed(a) < $signed(b))};
            default: r = 32'd0;
        endcase
        return {ov, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_op(input int id);
        logic [31:0] word;
        word = got_q[id] | {31'd0, slt_bit};
        check(tag_q[id], word, exp_q[id]);
        check("R5 ovf", {31'd0, ovf_flag}, {31'd0, eovf_q[id]});
        if (op_q[id] != 3'd6) check("R6 slt idle", {31'd0, slt_bit}, 32'd0);
    endtask

    task automatic step(input bit iv, input logic [2:0] iop, input logic [31:0] ia,
                        input logic [31:0] ib, input bit ifwd, input string tag);
        logic [32:0] r;
        @(negedge clk);
        for (int k = 0; k < SL; k++) begin
            int id = hidx[k];
            check((id >= 0) ? "R2 lane valid" : "R9 idle lane", {31'd0, res_vld[k]},
                  {31'd0, (id >= 0)});
            if (id >= 0) got_q[id][k*SW +: SW] = res_sk[k*SW +: SW];
            if (k == SL - 1) begin
                if (id >= 0) finish_op(id);
                else begin
                    check("R5 ovf idle", {31'd0, ovf_flag}, 32'd0);
                    check("R6 slt idle", {31'd0, slt_bit}, 32'd0);
                end
            end
        end
        for (int j = SL - 1; j > 0; j--) hidx[j] = hidx[j-1];
        hidx[0] = -1;
        if (iv) begin
            int id = nops;
            nops++;
            op_q[id]  = iop;
            a_q[id]   = (ifwd && id > 0) ? exp_q[id-1] : ia;
            b_q[id]   = ib;
            fwd_q[id] = ifwd;
            tag_q[id] = tag;
            got_q[id] = '0;
            r = ref_calc(iop, a_q[id], ib);
            exp_q[id]  = r[31:0];
            eovf_q[id] = r[32];
            hidx[0] = id;
        end
        issue_vld = iv;
        issue_op  = iv ? iop : 3'd5;
        for (int k = 0; k < SL; k++) begin
            int id = hidx[k];
            if (id >= 0) begin
                a_sk[k*SW +: SW] = fwd_q[id] ? res_sk[k*SW +: SW] : a_q[id][k*SW +: SW];
                b_sk[k*SW +: SW] = b_q[id][k*SW +: SW];
            end else begin
                a_sk[k*SW +: SW] = 4'hA;
                b_sk[k*SW +: SW] = 4'h5;
            end
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input string tag);
        step(1'b1, op, a, b, 1'b0, tag);
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 32'd0, 1'b0, "");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        for (int j = 0; j < SL; j++) hidx[j] = -1;
        repeat (3) @(negedge clk);
        check("R1 vld in reset", {24'd0, res_vld}, 32'd0);
        check("R1 flags in reset", {30'd0, ovf_flag, slt_bit}, 32'd0);
        rst_n = 1'b1;
        drain(2);
    endtask

    task automatic t_reset_midflight;
        issue(3'd0, 32'h7FFF_FFFF, 32'd1, "R3 add");
        issue(3'd6, 32'd1, 32'd2, "R6 slt");
        drain(3);
        t_reset();
        drain(SL + 1);
    endtask

    task automatic t_logic;
        issue(3'd2, 32'hF0F0_1234, 32'hFF00_FF0F, "R4 and");
        issue(3'd3, 32'h0F0F_0000, 32'h1000_8001, "R4 or");
        issue(3'd4, 32'hAAAA_5555, 32'hFFFF_0000, "R4 xor");
        issue(3'd5, 32'h1234_5678, 32'h8000_0001, "R4 nor");
        issue(3'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 or no ovf");
        drain(SL + 1);
    endtask

    task automatic t_addsub;
        issue(3'd0, 32'hFFFF_FFFF, 32'd1, "R3 add full ripple");
        issue(3'd0, 32'h0000_000F, 32'd1, "R3 add slice carry");
        issue(3'd1, 32'd0, 32'd1, "R3 sub borrow");
        issue(3'd1, 32'h1234_5678, 32'h1234_5678, "R3 sub equal");
        issue(3'd0, 32'h89AB_CDEF, 32'h7654_3211, "R3 add wrap");
        drain(SL + 1);
    endtask

    task automatic t_overflow;
        issue(3'd0, 32'h7FFF_FFFF, 32'd1, "R5 add pos ovf");
        issue(3'd1, 32'h8000_0000, 32'd1, "R5 sub neg ovf");
        issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R5 add neg ovf");
        issue(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R5 sub pos ovf");
        issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 add no ovf");
        drain(SL + 1);
    endtask

    task automatic t_slt;
        issue(3'd6, 32'hFFFF_FFFF, 32'd0, "R6 slt neg<0");
        issue(3'd6, 32'd5, 32'd5, "R6 slt equal");
        issue(3'd6, 32'h8000_0000, 32'd1, "R6 slt ovf true");
        issue(3'd6, 32'h7FFF_FFFF, 32'h8000_0000, "R6 slt ovf false");
        issue(3'd6, 32'd3, 32'd9, "R6 slt small");
        issue(3'd7, 32'hFFFF_FFFF, 32'd1, "R8 unused code");
        drain(SL + 1);
    endtask

    task automatic t_dependent;
        issue(3'd0, 32'h0FFF_FFF0, 32'h0000_0010, "R7 chain head");
        step(1'b1, 3'd0, 32'd0, 32'h7000_0001, 1'b1, "R7 fwd add ovf");
        step(1'b1, 3'd1, 32'd0, 32'h0000_0002, 1'b1, "R7 fwd sub");
        step(1'b1, 3'd4, 32'd0, 32'hFFFF_FFFF, 1'b1, "R7 fwd xor");
        step(1'b1, 3'd0, 32'd0, 32'h0000_0001, 1'b1, "R7 fwd add");
        step(1'b1, 3'd5, 32'd0, 32'h0000_00FF, 1'b1, "R7 fwd nor");
        step(1'b1, 3'd6, 32'd0, 32'h0000_0000, 1'b1, "R7 fwd slt");
        drain(SL + 1);
    endtask

    task automatic t_bubbles;
        issue(3'd0, 32'h0000_FFFF, 32'h0000_0001, "R9 add before gap");
        drain(1);
        issue(3'd1, 32'h0001_0000, 32'h0000_0001, "R9 sub after gap");
        drain(2);
        issue(3'd4, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R9 xor after gap");
        drain(SL + 1);
    endtask

    initial begin
        for (int j = 0; j < SL; j++) hidx[j] = -1;
        t_reset();
        t_logic();
        t_addsub();
        t_overflow();
        t_slt();
        t_dependent();
        t_bubbles();
        t_reset_midflight();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule